// File: doc/BRIEF.md
# External Bus Lending Arbiter

This block decides who drives the chip's external bus: the chip itself or an outside master that asks for it. The outside master pulls an active-low request line. When lending is enabled by a control bit, the block waits for a bus-cycle boundary. It then turns off the address, data and control drivers and, one cycle later, pulls its active-low acknowledge line. While the bus is lent, internal masters that want an external cycle are stalled, not refused. Refresh requests are stalled in the same way.

When a second control bit is set and work is waiting, an active-low return-request line asks the outside master to give the bus back. Once the outside request goes high, the acknowledge rises, the drivers come back one cycle later, and the deferred work resumes. Refresh goes first, then the internal masters in fixed index order.

The outside request line is asynchronous and passes through a synchronizer with a parameterised number of stages. Grants and stalls are combinational answers to the requesters. The pins and bus-driver enables are registered.

Top module: `xbus_lend_arb`

## Requirements
- R1: While `lend_en` is 0, a low level on `xreq_n` has no effect: `xack_n` and the three driver enables stay 1, and internal requests keep being granted.
- R2: With `lend_en` at 1 and no cycle active, the driver enables go to 0 on the 3rd rising edge after `xreq_n` falls, and `xack_n` goes to 0 on the 4th edge. The drivers are always off in the cycle before the acknowledge falls.
- R3: The bus is lent only when `cyc_busy` is 0. While an external cycle is active, a pending outside request waits.
- R4: While the bus is not owned (drivers off or acknowledge low), every bit of `mst_grant` is 0, and each requesting master sees its `mst_stall` bit at 1.
- R5: A refresh request raised while the bus is not owned is stalled (`rf_stall`=1, `rf_grant`=0) until the bus is back.
- R6: `xret_n` is driven to 0 on the edge after a cycle in which `ret_en` is 1, the bus is lent, and a master request or refresh is pending. In every other case it is 1 after the next edge.
- R7: After `xreq_n` rises, `xack_n` returns to 1 on the 3rd edge and `xret_n` returns to 1 on the same edge. The driver enables return to 1 one edge later.
- R8: If the outside request is won in the same cycle that an internal master requests, the outside request has priority: no grant is given in that cycle.
- R9: While the bus is owned and idle, refresh is granted ahead of any master request.
- R10: Among internal masters the lowest index wins. At most one of `mst_grant` and `rf_grant` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lend_en | input | 1 | Control bit: allow the bus to be lent out |
| ret_en | input | 1 | Control bit: allow the return-request pin |
| xreq_n | input | 1 | Asynchronous active-low request from the outside master |
| cyc_busy | input | 1 | An external bus cycle is in progress (high from the cycle after a grant) |
| mst_req | input | NUM_MST | Internal masters requesting an external access |
| rf_req | input | 1 | Refresh request |
| xack_n | output | 1 | Active-low acknowledge to the outside master |
| xret_n | output | 1 | Active-low request to return the bus |
| adr_oe | output | 1 | Address bus driver enable |
| dat_oe | output | 1 | Data bus driver enable |
| ctl_oe | output | 1 | Bus control driver enable |
| mst_grant | output | NUM_MST | Per-master grant to start an external cycle |
| mst_stall | output | NUM_MST | Per-master stall |
| rf_grant | output | 1 | Refresh may start |
| rf_stall | output | 1 | Refresh is held off |

## Verification
The bench counts edges from the request pin to the driver enables and the acknowledge, in both directions. A synchronizer one stage short, or drivers switched together with the acknowledge, would show up as a one-cycle shift. It drops `cyc_busy` in the same cycle that a master raises a request. A design that let the master win would grant a cycle while the drivers are turning off. It takes the bus back with both refresh and a master waiting: a wrong order would grant the master first. A return-request pin that ignored its enable, or that stayed low after the work was withdrawn, would be caught at the pin.

// File: rtl/xbl_pkg.sv
package xbl_pkg;
  typedef enum logic [1:0] {
    BUS_OWNED   = 2'd0,
    BUS_FLOAT   = 2'd1,
    BUS_LENT    = 2'd2,
    BUS_RECLAIM = 2'd3
  } xbl_state_e;
endpackage

// File: rtl/xbl_sync.sv
module xbl_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RST_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/xbl_fsm.sv
module xbl_fsm
  import xbl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lend_en,
  input  logic       ret_en,
  input  logic       req_act,
  input  logic       cyc_busy,
  input  logic       pending,
  output xbl_state_e st,
  output logic       lend_win,
  output logic       ack_n,
  output logic       ret_n,
  output logic       oe
);
  xbl_state_e st_q, st_d;
  logic ack_n_q, ret_n_q, oe_q;

  assign lend_win = (st_q == BUS_OWNED) && lend_en && req_act && !cyc_busy;

  always_comb begin
    st_d = st_q;
    case (st_q)
      BUS_OWNED:   if (lend_win) st_d = BUS_FLOAT;
      BUS_FLOAT:   st_d = req_act ? BUS_LENT : BUS_OWNED;
      BUS_LENT:    if (!req_act) st_d = BUS_RECLAIM;
      BUS_RECLAIM: st_d = BUS_OWNED;
      default:     st_d = BUS_OWNED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= BUS_OWNED;
      ack_n_q <= 1'b1;
      ret_n_q <= 1'b1;
      oe_q    <= 1'b1;
    end else begin
      st_q    <= st_d;
      ack_n_q <= !(st_d == BUS_LENT);
      ret_n_q <= !(ret_en && pending && (st_d == BUS_LENT));
      oe_q    <= (st_d == BUS_OWNED);
    end
  end

  assign st    = st_q;
  assign ack_n = ack_n_q;
  assign ret_n = ret_n_q;
  assign oe    = oe_q;

  assert_no_lend_disabled_R1: assert property (@(posedge clk) disable iff (rst)
    (st_q == BUS_OWNED && !lend_en) |=> (st_q == BUS_OWNED));
  assert_drivers_off_first_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_n_q) |-> !$past(oe_q));
  assert_cycle_boundary_R3: assert property (@(posedge clk) disable iff (rst)
    (st_q == BUS_OWNED && cyc_busy) |=> (st_q == BUS_OWNED));
  assert_ret_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
    !ret_en |=> ret_n_q);
  assert_drivers_back_late_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |-> $past(ack_n_q));
endmodule

// File: rtl/xbl_prio.sv
module xbl_prio #(
  parameter int NUM_MST = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               owned,
  input  logic               lend_win,
  input  logic               cyc_busy,
  input  logic [NUM_MST-1:0] mst_req,
  input  logic               rf_req,
  output logic [NUM_MST-1:0] mst_grant,
  output logic [NUM_MST-1:0] mst_stall,
  output logic               rf_grant,
  output logic               rf_stall
);
  logic slot_free;
  logic [NUM_MST:0] taken;

  assign slot_free = owned && !lend_win && !cyc_busy;
  assign rf_grant  = slot_free && rf_req;
  assign rf_stall  = rf_req && !rf_grant;
  assign taken[0]  = rf_req;

  for (genvar i = 0; i < NUM_MST; i++) begin : g_mst
    assign mst_grant[i] = slot_free && mst_req[i] && !taken[i];
    assign mst_stall[i] = mst_req[i] && !mst_grant[i];
    assign taken[i+1]   = taken[i] || mst_req[i];
  end

  assert_single_grant_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mst_grant, rf_grant}));
  assert_refresh_first_R9: assert property (@(posedge clk) disable iff (rst)
    rf_req |-> (mst_grant == '0));
  assert_external_wins_R8: assert property (@(posedge clk) disable iff (rst)
    lend_win |-> (mst_grant == '0 && !rf_grant));
endmodule

// File: rtl/xbus_lend_arb.sv
module xbus_lend_arb #(
  parameter int NUM_MST     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lend_en,
  input  logic               ret_en,
  input  logic               xreq_n,
  input  logic               cyc_busy,
  input  logic [NUM_MST-1:0] mst_req,
  input  logic               rf_req,
  output logic               xack_n,
  output logic               xret_n,
  output logic               adr_oe,
  output logic               dat_oe,
  output logic               ctl_oe,
  output logic [NUM_MST-1:0] mst_grant,
  output logic [NUM_MST-1:0] mst_stall,
  output logic               rf_grant,
  output logic               rf_stall
);
  import xbl_pkg::*;

  logic       xreq_sync_n, lend_win, oe, pending;
  xbl_state_e st;

  xbl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(xreq_n), .q(xreq_sync_n)
  );

  assign pending = (|mst_req) || rf_req;

  xbl_fsm u_fsm (
    .clk(clk), .rst(rst), .lend_en(lend_en), .ret_en(ret_en),
    .req_act(!xreq_sync_n), .cyc_busy(cyc_busy), .pending(pending),
    .st(st), .lend_win(lend_win), .ack_n(xack_n), .ret_n(xret_n), .oe(oe)
  );

  xbl_prio #(.NUM_MST(NUM_MST)) u_prio (
    .clk(clk), .rst(rst), .owned(st == BUS_OWNED), .lend_win(lend_win),
    .cyc_busy(cyc_busy), .mst_req(mst_req), .rf_req(rf_req),
    .mst_grant(mst_grant), .mst_stall(mst_stall),
    .rf_grant(rf_grant), .rf_stall(rf_stall)
  );

  assign adr_oe = oe;
  assign dat_oe = oe;
  assign ctl_oe = oe;

  assert_no_grant_while_lent_R4: assert property (@(posedge clk) disable iff (rst)
    (!xack_n || !adr_oe) |-> (mst_grant == '0));
  assert_refresh_held_R5: assert property (@(posedge clk) disable iff (rst)
    !xack_n |-> !rf_grant);
endmodule

// File: tb/xbus_lend_arb_test.sv
module xbus_lend_arb_test;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 2;

  logic clk = 1'b0;
  logic rst, lend_en, ret_en, xreq_n, cyc_busy, rf_req;
  logic [NM-1:0] mst_req;
  logic xack_n, xret_n, adr_oe, dat_oe, ctl_oe, rf_grant, rf_stall;
  logic [NM-1:0] mst_grant, mst_stall;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_lend_arb #(.NUM_MST(NM), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .lend_en(lend_en), .ret_en(ret_en), .xreq_n(xreq_n),
    .cyc_busy(cyc_busy), .mst_req(mst_req), .rf_req(rf_req),
    .xack_n(xack_n), .xret_n(xret_n), .adr_oe(adr_oe), .dat_oe(dat_oe),
    .ctl_oe(ctl_oe), .mst_grant(mst_grant), .mst_stall(mst_stall),
    .rf_grant(rf_grant), .rf_stall(rf_stall)
  );

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_oe(input string req, input logic exp);
    chk(req, {29'd0, adr_oe, dat_oe, ctl_oe}, exp ? 32'h7 : 32'h0);
  endtask

  task automatic t_reset;
    chk("R7 reset ack", xack_n, 1);
    chk("R6 reset ret", xret_n, 1);
    chk_oe("R2 reset oe", 1'b1);
    chk("R10 reset grants", {mst_grant, rf_grant}, 0);
  endtask

  task automatic t_disabled;
    lend_en = 0; xreq_n = 0;
    tick(8);
    chk("R1 ack", xack_n, 1);
    chk_oe("R1 oe", 1'b1);
    mst_req = 2'b01; #1;
    chk("R1 grant", mst_grant, 2'b01);
    mst_req = 0; xreq_n = 1;
    tick(4);
  endtask

  task automatic t_lend_and_return;
    lend_en = 1; ret_en = 0;
    xreq_n = 0;
    tick(2);
    chk_oe("R2 oe after 2", 1'b1);
    tick(1);
    chk_oe("R2 oe off after 3", 1'b0);
    chk("R2 ack still high", xack_n, 1);
    tick(1);
    chk("R2 ack low after 4", xack_n, 0);
    mst_req = 2'b01; #1;
    chk("R4 no grant lent", mst_grant, 0);
    chk("R4 stall lent", mst_stall, 2'b01);
    tick(1);
    chk("R6 ret disabled stays high", xret_n, 1);
    ret_en = 1;
    tick(1);
    chk("R6 ret low", xret_n, 0);
    mst_req = 0;
    tick(1);
    chk("R6 ret high when nothing pending", xret_n, 1);
    rf_req = 1; mst_req = 2'b10; #1;
    chk("R5 refresh stalled", {rf_grant, rf_stall}, 2'b01);
    tick(1);
    chk("R6 ret low again", xret_n, 0);
    xreq_n = 1;
    tick(2);
    chk("R7 ack low after 2", xack_n, 0);
    tick(1);
    chk("R7 ack high after 3", xack_n, 1);
    chk("R7 ret high with ack", xret_n, 1);
    chk_oe("R7 oe still off", 1'b0);
    chk("R5 refresh still stalled", rf_grant, 0);
    tick(1);
    chk_oe("R7 oe back", 1'b1);
    chk("R9 refresh first", {rf_grant, mst_grant}, 3'b100);
    chk("R9 master stalled", mst_stall, 2'b10);
    rf_req = 0; #1;
    chk("R9 master next", mst_grant, 2'b10);
    mst_req = 0;
    tick(2);
  endtask

  task automatic t_boundary_and_priority;
    lend_en = 1; ret_en = 0;
    cyc_busy = 1; xreq_n = 0;
    tick(6);
    chk_oe("R3 held during cycle", 1'b1);
    chk("R3 ack held", xack_n, 1);
    cyc_busy = 0; mst_req = 2'b01; #1;
    chk("R8 external wins", mst_grant, 0);
    chk("R8 master stalled", mst_stall, 2'b01);
    tick(1);
    chk_oe("R3 oe off after boundary", 1'b0);
    tick(1);
    chk("R3 ack low", xack_n, 0);
    mst_req = 0; xreq_n = 1;
    tick(4);
    chk_oe("R7 oe restored", 1'b1);
  endtask

  task automatic t_master_order;
    mst_req = 2'b11; #1;
    chk("R10 lowest index", mst_grant, 2'b01);
    chk("R10 other stalled", mst_stall, 2'b10);
    mst_req = 2'b10; #1;
    chk("R10 second master", mst_grant, 2'b10);
    mst_req = 0;
    tick(1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; lend_en = 0; ret_en = 0; xreq_n = 1; cyc_busy = 0;
    mst_req = 0; rf_req = 0;
    tick(3);
    rst = 0;
    tick(1);
    t_reset();
    t_disabled();
    t_lend_and_return();
    t_boundary_and_priority();
    t_master_order();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule